// File: doc/BRIEF.md
# Inversion Link Decoder with Gray-to-Binary Restore

This block sits on the receive side of a network interface, at the point where flits arrive from an on-chip link. The transmitter sends each payload word as the Gray code of the original binary data. It may also flip some bit positions of that word to reduce switching on the wires, and a small side-band field tells the receiver which flip was applied. The decoder undoes the flip with an XOR mask. The mask selects odd-index bits, even-index bits, every bit, or no bit. The decoder then turns the Gray word back into binary and presents the original flit on a registered output with a valid strobe.

Header flits carry routing information and were never coded. When the header flag is set, the decoder forwards the link word as it is and ignores the side-band. While no flit arrives, the output register keeps the last word it presented. The side-band width is a parameter. The two-bit form supports four actions. The one-bit form supports only "odd flip" or "no flip".

Top module: `inv_link_decoder`

## Requirements
- R1: While the synchronised reset is active, out_vld, out_hdr and out_data are all zero.
- R2: out_vld is high in the cycle after each clock edge that samples lnk_vld high, and low after each edge that samples it low.
- R3: Side-band code 00 means no flip: the link word goes to Gray-to-binary conversion unmodified (link 8'h80 gives 8'hFF).
- R4: Side-band code 10 flips back the bits at odd indices (1, 3, 5, ...), a mask of 8'hAA at width 8.
- R5: Side-band code 01 flips back the bits at even indices (0, 2, 4, ...), a mask of 8'h55 at width 8.
- R6: Side-band code 11 flips back every bit (link 8'h00 gives 8'hAA).
- R7: Gray-to-binary conversion copies the top bit and sets each lower bit i to binary bit i+1 XOR Gray bit i (link 8'hC0 with code 00 gives 8'h80).
- R8: A flit with lnk_hdr high is presented with its link word unchanged and out_hdr high, whatever the side-band holds.
- R9: In a cycle with lnk_vld low, out_data and out_hdr keep their previous values.
- R10: A flit that is Gray coded and then flipped by any of the four codes is restored exactly to the original binary word.
- R11: With a one-bit side-band, 1 selects the odd-index flip and 0 selects no flip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lnk_vld | input | 1 | A flit is present on the link this cycle |
| lnk_hdr | input | 1 | Present flit is a header and bypasses decoding |
| lnk_sb | input | SB_W | Flip code: 00 none, 10 odd, 01 even, 11 full (one-bit form: 1 odd) |
| lnk_data | input | PAY_W | Coded payload word from the link |
| out_vld | output | 1 | Registered strobe for out_data |
| out_hdr | output | 1 | Registered header flag |
| out_data | output | PAY_W | Restored binary flit |

## Verification
The assertions assume that lnk_vld, lnk_hdr, lnk_sb and lnk_data hold known values at every sampled edge after reset, and that the side-band code matches the flip actually applied on the transmit side. The bench meets both assumptions. It drives all inputs to defined values from time zero and changes them only on falling edges. It builds every coded payload itself: it takes the Gray code of the intended word and XORs in the mask that belongs to the chosen code. Header flits carry random-looking side-band values so that the bypass path is tested against codes it must ignore.

// File: rtl/inv_link_pkg.sv
package inv_link_pkg;

  // Flip action requested by the side-band
  typedef enum logic [1:0] {
    INV_NONE = 2'b00,
    INV_EVEN = 2'b01,
    INV_ODD  = 2'b10,
    INV_FULL = 2'b11
  } inv_mode_e;

endpackage

// File: rtl/inv_mode_decode.sv
module inv_mode_decode
  import inv_link_pkg::*;
#(
  parameter int SB_W = 2
) (
  input  logic [SB_W-1:0] sb,
  output inv_mode_e       mode
);

  generate
    if (SB_W == 1) begin : g_narrow
      // one-bit side-band: only odd flip or nothing
      always_comb begin
        mode = sb[0] ? INV_ODD : INV_NONE;
      end
    end else begin : g_wide
      always_comb begin
        unique case (sb[1:0])
          2'b10:   mode = INV_ODD;
          2'b01:   mode = INV_EVEN;
          2'b11:   mode = INV_FULL;
          default: mode = INV_NONE;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/inv_deinvert.sv
module inv_deinvert
  import inv_link_pkg::*;
#(
  parameter int PAY_W = 8
) (
  input  inv_mode_e          mode,
  input  logic [PAY_W-1:0]   din,
  output logic [PAY_W-1:0]   dout
);

  logic [PAY_W-1:0] odd_sel;
  logic [PAY_W-1:0] even_sel;
  logic [PAY_W-1:0] flip;

  // position masks built per lane
  genvar gi;
  generate
    for (gi = 0; gi < PAY_W; gi++) begin : g_lane
      assign odd_sel[gi]  = (gi % 2) == 1;
      assign even_sel[gi] = (gi % 2) == 0;
    end
  endgenerate

  always_comb begin
    unique case (mode)
      INV_ODD:  flip = odd_sel;
      INV_EVEN: flip = even_sel;
      INV_FULL: flip = '1;
      default:  flip = '0;
    endcase
    dout = din ^ flip;
  end

endmodule

// File: rtl/inv_gray2bin.sv
module inv_gray2bin #(
  parameter int PAY_W = 8
) (
  input  logic [PAY_W-1:0] gray,
  output logic [PAY_W-1:0] bin
);

  // serial prefix from the top bit down
  always_comb begin
    bin[PAY_W-1] = gray[PAY_W-1];
    for (int i = PAY_W - 2; i >= 0; i--) begin
      bin[i] = bin[i+1] ^ gray[i];
    end
  end

endmodule

// File: rtl/inv_link_decoder.sv
module inv_link_decoder
  import inv_link_pkg::*;
#(
  parameter int PAY_W = 8,
  parameter int SB_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lnk_vld,
  input  logic             lnk_hdr,
  input  logic [SB_W-1:0]  lnk_sb,
  input  logic [PAY_W-1:0] lnk_data,
  output logic             out_vld,
  output logic             out_hdr,
  output logic [PAY_W-1:0] out_data
);

  localparam int RS_STAGES = 2;

  function automatic logic [PAY_W-1:0] alt_mask(input bit odd_pos);
    logic [PAY_W-1:0] m;
    for (int i = 0; i < PAY_W; i++) begin
      m[i] = odd_pos ? (i % 2 == 1) : (i % 2 == 0);
    end
    return m;
  endfunction

  localparam logic [PAY_W-1:0] ODD_MASK  = alt_mask(1'b1);
  localparam logic [PAY_W-1:0] EVEN_MASK = alt_mask(1'b0);

  // reset: asynchronous assert, synchronous release
  logic [RS_STAGES-1:0] rs_q;
  logic                 rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[RS_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rs_q[RS_STAGES-1];

  // datapath
  inv_mode_e        mode_w;
  logic [PAY_W-1:0] deinv_w;
  logic [PAY_W-1:0] bin_w;

  inv_mode_decode #(.SB_W(SB_W)) mode_i (
    .sb   (lnk_sb),
    .mode (mode_w)
  );

  inv_deinvert #(.PAY_W(PAY_W)) flip_i (
    .mode (mode_w),
    .din  (lnk_data),
    .dout (deinv_w)
  );

  inv_gray2bin #(.PAY_W(PAY_W)) g2b_i (
    .gray (deinv_w),
    .bin  (bin_w)
  );

  // next-state
  logic             vld_d;
  logic             hdr_d;
  logic [PAY_W-1:0] data_d;
  logic             load_en;

  assign load_en = lnk_vld;

  always_comb begin
    vld_d  = lnk_vld;
    hdr_d  = out_hdr;
    data_d = out_data;
    if (load_en) begin
      hdr_d  = lnk_hdr;
      data_d = lnk_hdr ? lnk_data : bin_w;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_vld  <= 1'b0;
      out_hdr  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= vld_d;
      if (load_en) begin
        out_hdr  <= hdr_d;
        out_data <= data_d;
      end
    end
  end

  // checks
  assert_vld_follow_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lnk_vld |=> out_vld);
  assert_vld_drop_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lnk_vld |=> !out_vld);
  assert_none_pass_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lnk_vld && mode_w == INV_NONE) |-> deinv_w == lnk_data);
  assert_odd_mask_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lnk_vld && mode_w == INV_ODD) |-> (deinv_w ^ lnk_data) == ODD_MASK);
  assert_even_mask_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lnk_vld && mode_w == INV_EVEN) |-> (deinv_w ^ lnk_data) == EVEN_MASK);
  assert_full_mask_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lnk_vld && mode_w == INV_FULL) |-> (deinv_w ^ lnk_data) == '1);
  assert_gray_back_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lnk_vld && !lnk_hdr) |=> (out_data ^ (out_data >> 1)) == $past(deinv_w));
  assert_hdr_bypass_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lnk_vld && lnk_hdr) |=> (out_hdr && out_data == $past(lnk_data)));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lnk_vld |=> ($stable(out_data) && $stable(out_hdr)));

  generate
    if (SB_W == 1) begin : g_chk_narrow
      assert_narrow_odd_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
        lnk_sb[0] |-> mode_w == INV_ODD);
    end
  endgenerate

endmodule

// File: tb/inv_link_decoder_tb_top.sv
module inv_link_decoder_tb_top;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         lnk_vld;
  logic         lnk_hdr;
  logic [1:0]   lnk_sb;
  logic [0:0]   lnk_sb1;
  logic [W-1:0] lnk_data;
  logic         out_vld, out_hdr;
  logic [W-1:0] out_data;
  logic         n_vld, n_hdr;
  logic [W-1:0] n_data;

  int checks = 0;
  int errors = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  inv_link_decoder #(.PAY_W(W), .SB_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .lnk_vld(lnk_vld), .lnk_hdr(lnk_hdr),
    .lnk_sb(lnk_sb), .lnk_data(lnk_data),
    .out_vld(out_vld), .out_hdr(out_hdr), .out_data(out_data)
  );

  inv_link_decoder #(.PAY_W(W), .SB_W(1)) dut1_i (
    .clk(clk), .rst_n(rst_n), .lnk_vld(lnk_vld), .lnk_hdr(lnk_hdr),
    .lnk_sb(lnk_sb1), .lnk_data(lnk_data),
    .out_vld(n_vld), .out_hdr(n_hdr), .out_data(n_data)
  );

  // {hdr, code, original binary word}
  localparam logic [10:0] VEC [12] = '{
    {1'b0, 2'b00, 8'h00}, {1'b0, 2'b00, 8'h5A},
    {1'b0, 2'b10, 8'h3C}, {1'b0, 2'b10, 8'hFF},
    {1'b0, 2'b01, 8'h81}, {1'b0, 2'b01, 8'h7E},
    {1'b0, 2'b11, 8'h00}, {1'b0, 2'b11, 8'hC3},
    {1'b1, 2'b11, 8'h96}, {1'b1, 2'b10, 8'h01},
    {1'b0, 2'b10, 8'h80}, {1'b0, 2'b01, 8'h01}
  };

  function automatic logic [W-1:0] code_mask(input logic [1:0] code);
    case (code)
      2'b10:   return 8'hAA;
      2'b01:   return 8'h55;
      2'b11:   return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [W-1:0] tx_code(input logic [W-1:0] b, input logic [1:0] code);
    return (b ^ (b >> 1)) ^ code_mask(code);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic hdr, input logic [1:0] sb, input logic [W-1:0] d);
    @(negedge clk);
    lnk_vld  = 1'b1;
    lnk_hdr  = hdr;
    lnk_sb   = sb;
    lnk_sb1  = sb[1];
    lnk_data = d;
    @(negedge clk);
    lnk_vld  = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lnk_vld = 1'b0; lnk_hdr = 1'b0;
    lnk_sb = 2'b00; lnk_sb1 = 1'b0; lnk_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 out_vld", {7'd0, out_vld}, 8'h00);
    chk("R1 out_hdr", {7'd0, out_hdr}, 8'h00);
    chk("R1 out_data", out_data, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // loopback table
    for (int k = 0; k < 12; k++) begin
      logic [W-1:0] wd;
      wd = VEC[k][10] ? VEC[k][7:0] : tx_code(VEC[k][7:0], VEC[k][9:8]);
      send(VEC[k][10], VEC[k][9:8], wd);
      chk(VEC[k][10] ? "R8 table header" : "R10 table loopback", out_data, VEC[k][7:0]);
      chk("R2 strobe", {7'd0, out_vld}, 8'h01);
      chk("R8 hdr flag", {7'd0, out_hdr}, {7'd0, VEC[k][10]});
    end

    // directed corners
    send(1'b0, 2'b00, 8'h80); chk("R3 none", out_data, 8'hFF);
    send(1'b0, 2'b10, 8'hAA); chk("R4 odd", out_data, 8'h00);
    send(1'b0, 2'b01, 8'h55); chk("R5 even", out_data, 8'h00);
    send(1'b0, 2'b11, 8'h00); chk("R6 full", out_data, 8'hAA);
    send(1'b0, 2'b00, 8'hC0); chk("R7 prefix", out_data, 8'h80);
    send(1'b0, 2'b00, 8'h01); chk("R7 lsb", out_data, 8'h01);
    send(1'b1, 2'b11, 8'h3C); chk("R8 bypass", out_data, 8'h3C);
    chk("R8 flag", {7'd0, out_hdr}, 8'h01);

    // idle: output holds, strobe low
    @(negedge clk);
    lnk_data = 8'hF0; lnk_hdr = 1'b0; lnk_sb = 2'b11;
    repeat (3) @(negedge clk);
    chk("R9 hold data", out_data, 8'h3C);
    chk("R9 hold hdr", {7'd0, out_hdr}, 8'h01);
    chk("R2 idle strobe", {7'd0, out_vld}, 8'h00);

    // one-bit side-band instance
    send(1'b0, 2'b10, 8'hAA); chk("R11 narrow odd", n_data, 8'h00);
    send(1'b0, 2'b00, 8'h80); chk("R11 narrow none", n_data, 8'hFF);

    // reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reassert", out_data, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule